// File: doc/BRIEF.md
# Ethernet receive destination filter

This block sits on the receive path of an Ethernet controller. Each incoming frame arrives as a byte stream with start and end markers. The block looks at the first six bytes, which carry the destination address. It checks them against the receive-control enables and a programmed station address, then either forwards the frame or discards it. Every frame that ends produces a single result word. The word holds an accept flag, the stored length, status bits that name the match class which admitted the frame, and an interrupt request.

The block holds back its output until the eighth byte of a frame has arrived. By that point the destination address is complete and the minimum-length rule can be decided, so a rejected frame never puts a byte on the output. Once a frame is accepted it streams through eight bytes behind the input. Frames longer than the maximum are cut. Short frames are rebuilt to the minimum size: zero padding plus a freshly computed frame check sequence. While the block emits those trailing bytes it lowers its input-ready signal.

Top module: `eth_rx_dest_filter`

## Requirements
- R1: While `rx_en` is low at the start byte of a frame, that frame produces no output bytes and a result with `res_accept`=0.
- R2: With `promisc_en` set, every frame of at least 8 bytes is accepted, whatever its destination. No class bit is set: `res_status`=0x0100.
- R3: An all-ones destination is accepted only if `bcast_en` is set, with status 0x0900 (bit 11 = broadcast, bit 8 = receive OK). If `bcast_en` is clear, the frame is rejected, even when the station address is all ones and `ucast_en` is set.
- R4: A destination that is not all ones and has bit 0 of its first byte set is accepted only if `mcast_en` is set, with status 0x0300 (bit 9 = multicast). Otherwise it is rejected.
- R5: Any other destination is accepted only if `ucast_en` is set and all six bytes equal `station_addr`. `station_addr` holds the first byte on the wire in bits [7:0]. Such a frame gets status 0x0500 (bit 10 = individual). A one-byte mismatch, or `ucast_en` clear, rejects the frame.
- R6: A frame shorter than 8 bytes is rejected and produces no output bytes.
- R7: An accepted frame of 8 to 63 bytes is output as 64 bytes: its first min(len,60) bytes, zeros up to byte 60, and then a CRC-32 of those 60 bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, is seeded with all ones and is inverted at the end. `res_len`=64.
- R8: An accepted frame of 64 to 1518 bytes is output unchanged, with `res_len` equal to its length. A longer frame is output as its first 1518 bytes, with `res_len`=1518.
- R9: Every frame end produces one `res_valid` pulse. On acceptance, `res_accept`=1 and `res_status` carries bit 8 (0x0100). On rejection, `res_accept`, `res_len`, `res_status` and `res_irq` are all zero.
- R10: `res_irq` is high with an accepted result exactly when `rxok_ie` is set.
- R11: `out_sof` marks the first output byte of a frame and `out_eof` the last. An accepted result appears in the same cycle as `out_eof`.
- R12: `in_ready` is high after reset and while bytes are being taken. It is low from the end byte of an accepted frame until the last output byte of that frame has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable, sampled at each start byte |
| promisc_en | input | 1 | Accept all destinations |
| bcast_en | input | 1 | Accept the all-ones destination |
| mcast_en | input | 1 | Accept group destinations |
| ucast_en | input | 1 | Accept frames addressed to the station |
| rxok_ie | input | 1 | Raise an interrupt request on acceptance |
| station_addr | input | 48 | Station address, first wire byte in [7:0] |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_data | output | 8 | Output byte |
| res_valid | output | 1 | Frame result valid |
| res_accept | output | 1 | Frame was accepted |
| res_len | output | 11 | Stored frame length |
| res_status | output | 16 | Receive-OK and match-class bits |
| res_irq | output | 1 | Receive interrupt request |

## Verification
The filter is driven with unicast, multicast and broadcast destinations under different enable mixes. These separate the class order: promiscuous admits a broadcast with no class bit, and a disabled broadcast stops an all-ones destination that would otherwise match the station address. A unicast frame that differs only in the last address byte shows whether all six bytes are compared. Lengths of 5, 7, 8, 42, 62, 63, 64, 1518 and 1600 bytes cover the runt rejection, padding with and without dropping original bytes past 60, the unpadded boundary, and truncation. A reference CRC in the bench checks the four appended bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_FLUSH,
        S_PAD,
        S_FCS,
        S_DROP
    } rxf_state_e;

    // status bits decoded by the receive event/status consumer
    localparam logic [15:0] STAT_RX_OK = 16'h0100;
    localparam logic [15:0] STAT_MULTI = 16'h0200;
    localparam logic [15:0] STAT_UNI   = 16'h0400;
    localparam logic [15:0] STAT_BCAST = 16'h0800;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

endpackage

// File: rtl/rxf_classify.sv
// Destination classification in strict priority order.
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int ADDR_LEN = 6
) (
    input  logic [8*ADDR_LEN-1:0] dest,
    input  logic [8*ADDR_LEN-1:0] station,
    input  logic                  promisc_en,
    input  logic                  bcast_en,
    input  logic                  mcast_en,
    input  logic                  ucast_en,
    output logic                  accept,
    output logic [15:0]           cls
);

    always_comb begin
        accept = 1'b0;
        cls    = '0;
        if (promisc_en) begin
            accept = 1'b1;
        end else if (&dest) begin
            if (bcast_en) begin
                accept = 1'b1;
                cls    = STAT_BCAST;
            end
        end else if (dest[0]) begin
            if (mcast_en) begin
                accept = 1'b1;
                cls    = STAT_MULTI;
            end
        end else if (ucast_en && (dest == station)) begin
            accept = 1'b1;
            cls    = STAT_UNI;
        end
    end

endmodule

// File: rtl/rxf_crc_step.sv
// One byte of reflected CRC-32 update, LSB of the byte first.
module rxf_crc_step
    import rxf_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);

    logic [31:0] acc;

    always_comb begin
        acc = crc_in ^ {24'h0, data};
        for (int i = 0; i < 8; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ CRC_POLY_REFL) : (acc >> 1);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/eth_rx_dest_filter.sv
module eth_rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_LEN  = 6,
    parameter int MIN_FRAME = 8,     // also the output hold-back depth; must exceed ADDR_LEN
    parameter int MAX_FRAME = 1518,
    parameter int PAD_LEN   = 60,
    parameter int FCS_LEN   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 promisc_en,
    input  logic                 bcast_en,
    input  logic                 mcast_en,
    input  logic                 ucast_en,
    input  logic                 rxok_ie,
    input  logic [8*ADDR_LEN-1:0] station_addr,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic                 out_sof,
    output logic                 out_eof,
    output logic [7:0]           out_data,
    output logic                 res_valid,
    output logic                 res_accept,
    output logic [$clog2(MAX_FRAME+1)-1:0] res_len,
    output logic [15:0]          res_status,
    output logic                 res_irq
);

    localparam int LEN_W    = $clog2(MAX_FRAME + 1);
    localparam int IDX_W    = $clog2(MIN_FRAME);
    localparam int RUNT_LEN = PAD_LEN + FCS_LEN;
    localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_FRAME);
    localparam logic [LEN_W-1:0] PAD_L   = LEN_W'(PAD_LEN);
    localparam logic [LEN_W-1:0] RUNT_L  = LEN_W'(RUNT_LEN);
    localparam logic [LEN_W-1:0] DECIDE_L = LEN_W'(MIN_FRAME - 1);

    typedef struct packed {
        rxf_state_e                 st;
        logic [MIN_FRAME-1:0][7:0]  line;
        logic [LEN_W-1:0]           in_cnt;
        logic [LEN_W-1:0]           out_cnt;
        logic [31:0]                crc;
        logic [15:0]                cls;
        logic                       ov;
        logic                       osof;
        logic                       oeof;
        logic [7:0]                 odata;
        logic                       rv;
        logic                       racc;
        logic                       rirq;
        logic [LEN_W-1:0]           rlen;
        logic [15:0]                rstat;
    } rxf_regs_t;

    rxf_regs_t r_d, r_q;

    // ---------------- helpers ----------------
    logic        cls_accept;
    logic [15:0] cls_bits;
    logic [7:0]  crc_byte;
    logic [31:0] crc_nxt;
    logic [1:0]  fcs_idx;
    logic [31:0] fcs_word;
    logic [7:0]  fcs_byte;
    logic        take;

    rxf_classify #(.ADDR_LEN(ADDR_LEN)) u_classify (
        .dest       (r_q.line[ADDR_LEN-1:0]),
        .station    (station_addr),
        .promisc_en (promisc_en),
        .bcast_en   (bcast_en),
        .mcast_en   (mcast_en),
        .ucast_en   (ucast_en),
        .accept     (cls_accept),
        .cls        (cls_bits)
    );

    assign crc_byte = (r_q.st == S_PAD) ? 8'h00 : r_q.line[0];

    rxf_crc_step u_crc (
        .crc_in  (r_q.crc),
        .data    (crc_byte),
        .crc_out (crc_nxt)
    );

    assign fcs_idx  = 2'(r_q.out_cnt - PAD_L);
    assign fcs_word = ~r_q.crc;

    always_comb begin
        case (fcs_idx)
            2'd0:    fcs_byte = fcs_word[7:0];
            2'd1:    fcs_byte = fcs_word[15:8];
            2'd2:    fcs_byte = fcs_word[23:16];
            default: fcs_byte = fcs_word[31:24];
        endcase
    end

    assign in_ready = (r_q.st == S_IDLE) || (r_q.st == S_HEAD) ||
                      (r_q.st == S_BODY) || (r_q.st == S_DROP);
    assign take     = in_valid && in_ready;

    // ---------------- next state ----------------
    always_comb begin
        r_d       = r_q;
        r_d.ov    = 1'b0;
        r_d.osof  = 1'b0;
        r_d.oeof  = 1'b0;
        r_d.odata = 8'h00;
        r_d.rv    = 1'b0;
        r_d.racc  = 1'b0;
        r_d.rirq  = 1'b0;
        r_d.rlen  = '0;
        r_d.rstat = '0;

        case (r_q.st)
            S_IDLE: begin
                if (take && in_sof) begin
                    r_d.line    = '0;
                    r_d.line[0] = in_data;
                    r_d.in_cnt  = LEN_W'(1);
                    r_d.out_cnt = '0;
                    r_d.crc     = '1;
                    r_d.cls     = '0;
                    if (in_eof) begin
                        r_d.rv = 1'b1;              // runt: reject
                        r_d.st = S_IDLE;
                    end else begin
                        r_d.st = rx_en ? S_HEAD : S_DROP;
                    end
                end
            end

            S_HEAD: begin
                if (take) begin
                    r_d.line[r_q.in_cnt[IDX_W-1:0]] = in_data;
                    r_d.in_cnt = r_q.in_cnt + LEN_W'(1);
                    if (r_q.in_cnt == DECIDE_L) begin
                        r_d.cls = cls_bits;
                        if (!cls_accept) begin
                            if (in_eof) begin
                                r_d.rv = 1'b1;
                                r_d.st = S_IDLE;
                            end else begin
                                r_d.st = S_DROP;
                            end
                        end else begin
                            r_d.st = in_eof ? S_FLUSH : S_BODY;
                        end
                    end else if (in_eof) begin
                        r_d.rv = 1'b1;              // shorter than minimum
                        r_d.st = S_IDLE;
                    end
                end
            end

            S_BODY: begin
                if (take) begin
                    if (r_q.in_cnt != MAX_L) begin
                        r_d.ov      = 1'b1;
                        r_d.odata   = r_q.line[0];
                        r_d.osof    = (r_q.out_cnt == '0);
                        r_d.out_cnt = r_q.out_cnt + LEN_W'(1);
                        r_d.crc     = crc_nxt;
                        r_d.line    = {in_data, r_q.line[MIN_FRAME-1:1]};
                        r_d.in_cnt  = r_q.in_cnt + LEN_W'(1);
                    end
                    if (in_eof) begin
                        r_d.st = S_FLUSH;
                    end
                end
            end

            S_FLUSH: begin
                r_d.ov      = 1'b1;
                r_d.odata   = r_q.line[0];
                r_d.osof    = (r_q.out_cnt == '0);
                r_d.out_cnt = r_q.out_cnt + LEN_W'(1);
                r_d.crc     = crc_nxt;
                r_d.line    = {8'h00, r_q.line[MIN_FRAME-1:1]};
                if ((r_q.in_cnt < RUNT_L) && (r_q.out_cnt + LEN_W'(1) == PAD_L)) begin
                    r_d.st = S_FCS;
                end else if (r_q.out_cnt + LEN_W'(1) == r_q.in_cnt) begin
                    if (r_q.in_cnt < RUNT_L) begin
                        r_d.st = S_PAD;
                    end else begin
                        r_d.oeof  = 1'b1;
                        r_d.rv    = 1'b1;
                        r_d.racc  = 1'b1;
                        r_d.rirq  = rxok_ie;
                        r_d.rlen  = r_q.in_cnt;
                        r_d.rstat = r_q.cls | STAT_RX_OK;
                        r_d.st    = S_IDLE;
                    end
                end
            end

            S_PAD: begin
                r_d.ov      = 1'b1;
                r_d.odata   = 8'h00;
                r_d.out_cnt = r_q.out_cnt + LEN_W'(1);
                r_d.crc     = crc_nxt;
                if (r_q.out_cnt + LEN_W'(1) == PAD_L) begin
                    r_d.st = S_FCS;
                end
            end

            S_FCS: begin
                r_d.ov      = 1'b1;
                r_d.odata   = fcs_byte;
                r_d.out_cnt = r_q.out_cnt + LEN_W'(1);
                if (r_q.out_cnt == RUNT_L - LEN_W'(1)) begin
                    r_d.oeof  = 1'b1;
                    r_d.rv    = 1'b1;
                    r_d.racc  = 1'b1;
                    r_d.rirq  = rxok_ie;
                    r_d.rlen  = RUNT_L;
                    r_d.rstat = r_q.cls | STAT_RX_OK;
                    r_d.st    = S_IDLE;
                end
            end

            S_DROP: begin
                if (take && in_eof) begin
                    r_d.rv = 1'b1;
                    r_d.st = S_IDLE;
                end
            end

            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid  = r_q.ov;
    assign out_sof    = r_q.osof;
    assign out_eof    = r_q.oeof;
    assign out_data   = r_q.odata;
    assign res_valid  = r_q.rv;
    assign res_accept = r_q.racc;
    assign res_len    = r_q.rlen;
    assign res_status = r_q.rstat;
    assign res_irq    = r_q.rirq;

    // ---------------- assertions ----------------
    assert_reject_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> (res_status == '0 && res_len == '0 && !res_irq));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_irq |-> (res_valid && res_accept));

    assert_accept_on_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> (out_valid && out_eof));

    assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> (res_len >= RUNT_L && res_len <= MAX_L));

    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0(res_status[11:9]));

    assert_drop_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DROP) |=> !out_valid);

    assert_busy_while_trailing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof && !in_ready) |=> (out_valid || res_valid));

endmodule

// File: tb/eth_rx_dest_filter_tb.sv
module eth_rx_dest_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, promisc_en = 1'b0, bcast_en = 1'b0;
    logic        mcast_en = 1'b0, ucast_en = 1'b0, rxok_ie = 1'b0;
    logic [47:0] station_addr = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic        res_valid, res_accept, res_irq;
    logic [10:0] res_len;
    logic [15:0] res_status;

    always #2.5 clk = ~clk;   // 200 MHz

    eth_rx_dest_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .promisc_en(promisc_en),
        .bcast_en(bcast_en), .mcast_en(mcast_en), .ucast_en(ucast_en),
        .rxok_ie(rxok_ie), .station_addr(station_addr),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_data(out_data), .res_valid(res_valid),
        .res_accept(res_accept), .res_len(res_len), .res_status(res_status),
        .res_irq(res_irq)
    );

    int tests = 0;
    int fails = 0;

    // configuration requested by the test sequence
    logic c_rx = 1'b1, c_prom = 1'b0, c_bc = 1'b0, c_mc = 1'b0, c_uc = 1'b0, c_ie = 1'b0;
    logic [47:0] c_sta = 48'h1A2B3C4D5E02;

    // scoreboard queues
    logic [9:0]  exp_b[$];
    string       exp_btag[$];
    logic [28:0] exp_r[$];
    string       exp_rtag[$];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] bq[$]);
        logic [31:0] r;
        r = 32'hFFFFFFFF;
        foreach (bq[k]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = r[0] ^ bq[k][b];
                r  = r >> 1;
                if (fb) r = r ^ 32'hEDB88320;
            end
        end
        return ~r;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_b.size() == 0) begin
                    check("R11 unexpected output byte", {22'h0, out_sof, out_eof, out_data}, 32'h0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_b.pop_front();
                    t = exp_btag.pop_front();
                    check(t, {22'h0, out_sof, out_eof, out_data}, {22'h0, e});
                end
            end
            if (res_valid) begin
                if (exp_r.size() == 0) begin
                    check("R9 unexpected result", {3'h0, res_accept, res_irq, res_len, res_status}, 32'h0);
                end else begin
                    logic [28:0] e;
                    string t;
                    e = exp_r.pop_front();
                    t = exp_rtag.pop_front();
                    check(t, {3'h0, res_accept, res_irq, res_len, res_status}, {3'h0, e});
                end
            end
        end
    end

    // driver: builds the frame, predicts the outcome, drives it
    task automatic send(input logic [47:0] da, input int n, input int seed, input string tag);
        logic [7:0]  fr[$];
        logic [7:0]  ob[$];
        logic        acc;
        logic [15:0] cls;
        logic [31:0] c;
        int          m;
        for (int i = 0; i < n; i++) begin
            if (i < 6) fr.push_back(da[8*i +: 8]);
            else       fr.push_back(8'(i * 13 + seed));
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        rx_en = c_rx; promisc_en = c_prom; bcast_en = c_bc; mcast_en = c_mc;
        ucast_en = c_uc; rxok_ie = c_ie; station_addr = c_sta;

        acc = 1'b0;
        cls = 16'h0;
        if (c_rx && n >= 8) begin
            if (c_prom) acc = 1'b1;
            else if (da == 48'hFFFFFFFFFFFF) begin acc = c_bc; cls = 16'h0800; end
            else if (da[0]) begin acc = c_mc; cls = 16'h0200; end
            else if (c_uc && da == c_sta) begin acc = 1'b1; cls = 16'h0400; end
        end
        if (acc) begin
            if (n < 64) begin
                for (int i = 0; i < 60; i++) ob.push_back(i < n ? fr[i] : 8'h00);
                c = ref_crc(ob);
                for (int k = 0; k < 4; k++) ob.push_back(c[8*k +: 8]);
            end else begin
                m = (n > 1518) ? 1518 : n;
                for (int i = 0; i < m; i++) ob.push_back(fr[i]);
            end
            foreach (ob[i]) begin
                exp_b.push_back({(i == 0), (i == ob.size() - 1), ob[i]});
                exp_btag.push_back({tag, " byte/R11"});
            end
            exp_r.push_back({1'b1, c_ie, 11'(ob.size()), cls | 16'h0100});
        end else begin
            exp_r.push_back(29'h0);
        end
        exp_rtag.push_back({tag, " result/R9"});

        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = fr[i];
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        check({tag, " ready after end R12"}, {31'h0, in_ready}, {31'h0, !acc});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset in_ready", {31'h0, in_ready}, 32'h1);
        check("R9 reset res_valid", {31'h0, res_valid}, 32'h0);
        check("R11 reset out_valid", {31'h0, out_valid}, 32'h0);

        // R1: receiver disabled
        c_rx = 0; c_uc = 1;
        send(48'h1A2B3C4D5E02, 70, 1, "R1 rx disabled");
        c_rx = 1; c_uc = 0;

        // R2: promiscuous, unicast and broadcast
        c_prom = 1;
        send(48'h998877665544, 100, 2, "R2 promisc unicast");
        c_bc = 1;
        send(48'hFFFFFFFFFFFF, 70, 3, "R2 promisc over broadcast");
        c_prom = 0;

        // R3: broadcast
        send(48'hFFFFFFFFFFFF, 64, 4, "R3 broadcast accept R8 64 bytes");
        c_bc = 0; c_uc = 1; c_mc = 1; c_sta = 48'hFFFFFFFFFFFF;
        send(48'hFFFFFFFFFFFF, 70, 5, "R3 broadcast disabled");
        c_sta = 48'h1A2B3C4D5E02; c_uc = 0;

        // R4: multicast
        send(48'h0000005E0001, 80, 6, "R4 multicast accept");
        c_mc = 0; c_uc = 1;
        send(48'h0000005E0001, 80, 7, "R4 multicast disabled");

        // R5 / R10: unicast
        c_ie = 1;
        send(48'h1A2B3C4D5E02, 72, 8, "R5 unicast match R10 irq");
        send(48'h1B2B3C4D5E02, 72, 9, "R5 unicast last byte mismatch");
        c_uc = 0;
        send(48'h1A2B3C4D5E02, 72, 10, "R5 no class enabled");

        // R6 / R7: short frames
        c_prom = 1; c_ie = 0;
        send(48'h1A2B3C4D5E02, 5, 11, "R6 five bytes");
        send(48'h1A2B3C4D5E02, 7, 12, "R6 seven bytes");
        send(48'h1A2B3C4D5E02, 8, 13, "R7 eight bytes R10 no irq");
        send(48'h1A2B3C4D5E02, 42, 14, "R7 forty-two bytes");
        send(48'h1A2B3C4D5E02, 62, 15, "R7 sixty-two bytes");
        send(48'h1A2B3C4D5E02, 63, 16, "R7 sixty-three bytes");

        // R8: long frames
        c_ie = 1;
        send(48'h1A2B3C4D5E02, 1518, 17, "R8 maximum length");
        send(48'h1A2B3C4D5E02, 1600, 18, "R8 truncated");
        send(48'h1A2B3C4D5E02, 65, 19, "R8 sixty-five bytes");

        repeat (200) begin
            if (exp_b.size() != 0 || exp_r.size() != 0) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        check("R11 output queue drained", 32'(exp_b.size()), 32'h0);
        check("R9 result queue drained", 32'(exp_r.size()), 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule